// File: doc/BRIEF.md
# Refresh Row Counter with Programmable Wrap Point

This block keeps the row address used for DRAM refresh cycles. The counter is nine bits wide and advances by one for each refresh strobe. The refresh sequencer puts the count on the DRAM address bus. The wrap point is one of three limits, 127, 255 or 511, chosen by a two-bit select. The select is captured on a load strobe while the memory controller is in its set-up mode. A power-up reset sets the count to zero and the limit to 127.

A single active-low indicator line carries two things. The block pulls it low while the count equals the chosen limit, which tells the system that a full refresh pass is complete. Logic outside the block can also pull the line low to clear the counter. On the block boundary this line is split into an input and an output. The output is a combinational function of the registered count and limit. The input is sampled on the rising clock edge. Arbitration between refresh and access, and the timing of the strobes, belong to the surrounding controller.

Top module: `refresh_row_counter`

## Requirements
- R1: While `rstN` is low and after it is released, `rowAddr` is 0, the limit is 127, and `eocOutN` is 1.
- R2: On a clock edge with `incStrobe` high, `eocInN` high and the count below the limit, `rowAddr` goes up by one. With neither strobe active, `rowAddr` keeps its value.
- R3: On a clock edge with `loadStrobe` high, the limit is taken from `limitSel`: 00 selects 127, 01 selects 255, and 10 or 11 selects 511. The new limit applies from the following cycle.
- R4: `eocOutN` is 0 exactly while `rowAddr` equals the current limit, and 1 at every other time, including when the count is above the limit.
- R5: An increment taken while the count equals the limit sets `rowAddr` to 0, which returns `eocOutN` to 1.
- R6: An increment taken while the count is above the limit, which happens after a smaller limit has been loaded, also sets `rowAddr` to 0.
- R7: `eocInN` sampled low on a clock edge sets `rowAddr` to 0.
- R8: When `eocInN` is low and `incStrobe` is high on the same edge, the result is 0. The clear wins.
- R9: With the 511 limit, the counter goes through all nine bits. It reaches 511 with `eocOutN` low, and the next increment gives 0.
- R10: A limit load leaves `rowAddr` unchanged, including when it comes on the same edge as an increment, where only the increment takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-up reset, active low |
| incStrobe | input | 1 | Advance the row count by one refresh step |
| loadStrobe | input | 1 | Capture a new limit from limitSel |
| limitSel | input | 2 | Limit code: 00 gives 127, 01 gives 255, 1x gives 511 |
| eocInN | input | 1 | Level seen on the shared indicator line; low clears the count |
| eocOutN | output | 1 | Drive level for the shared indicator; low while the count equals the limit |
| rowAddr | output | 9 | Current refresh row address |

## Verification
The bench aims at the edges between counting and wrapping. A design that compares only for equality would run past a limit that was lowered below the current count, up to 511, and R6 catches that. A design that lets the increment win over the external clear would leave 1 instead of 0. A design that mixes up the two upper select codes would make 11 wrap at 127 or 255 instead of 511. The full 511 run and the reset in the middle of counting check that the indicator drops on the last row and nowhere else, and that reset restores the 127 limit as well as the count.

// File: rtl/refresh_row_pkg.sv
package refresh_row_pkg;

  // Strobes passed from the control to the datapath each cycle.
  typedef struct packed {
    logic clear;      // external clear sampled this edge
    logic advance;    // count step requested and not overridden
    logic wrap;       // step returns to zero instead of adding one
    logic loadLimit;  // capture a new limit code
  } rowCtl_t;

endpackage

// File: rtl/refresh_row_ctl.sv
module refresh_row_ctl
  import refresh_row_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    incStrobe,
  input  logic    loadStrobe,
  input  logic    eocInN,
  input  logic    atOrPastLimit,
  output rowCtl_t ctl
);

  always_comb begin
    ctl.clear     = !eocInN;
    ctl.advance   = incStrobe && eocInN;
    ctl.wrap      = incStrobe && eocInN && atOrPastLimit;
    ctl.loadLimit = loadStrobe;
  end

  // An external low on the line must override any step request (R8)
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (incStrobe && !eocInN) |-> (!ctl.advance && !ctl.wrap));

endmodule

// File: rtl/refresh_row_dp.sv
module refresh_row_dp
  import refresh_row_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  rowCtl_t          ctl,
  input  logic [SEL_W-1:0] limitSel,
  output logic [CNT_W-1:0] count,
  output logic             atOrPastLimit,
  output logic             eocOutN
);

  localparam logic [CNT_W-1:0] LIM_LOW  = CNT_W'((1 << (CNT_W - 2)) - 1);
  localparam logic [CNT_W-1:0] LIM_MID  = CNT_W'((1 << (CNT_W - 1)) - 1);
  localparam logic [CNT_W-1:0] LIM_HIGH = {CNT_W{1'b1}};

  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] limitNext;

  always_comb begin
    if (limitSel == SEL_W'(0))      limitNext = LIM_LOW;
    else if (limitSel == SEL_W'(1)) limitNext = LIM_MID;
    else                            limitNext = LIM_HIGH;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              limit <= LIM_LOW;
    else if (ctl.loadLimit) limit <= limitNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '0;
    else if (ctl.clear)   count <= '0;
    else if (ctl.advance) count <= ctl.wrap ? '0 : count + 1'b1;
  end

  assign atOrPastLimit = (count >= limit);
  assign eocOutN       = (count != limit);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !ctl.wrap && !ctl.clear) |=> (count == $past(count) + 1'b1));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.advance && !ctl.clear) |=> $stable(count));

  assert_limit_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadLimit |=> (limit == LIM_LOW || limit == LIM_MID || limit == LIM_HIGH));

  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrap |=> (count == '0));

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (count == '0));

endmodule

// File: rtl/refresh_row_counter.sv
module refresh_row_counter
  import refresh_row_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             incStrobe,
  input  logic             loadStrobe,
  input  logic [SEL_W-1:0] limitSel,
  input  logic             eocInN,
  output logic             eocOutN,
  output logic [CNT_W-1:0] rowAddr
);

  rowCtl_t ctl;
  logic    atOrPastLimit;

  refresh_row_ctl i_ctl (
    .clk           (clk),
    .rstN          (rstN),
    .incStrobe     (incStrobe),
    .loadStrobe    (loadStrobe),
    .eocInN        (eocInN),
    .atOrPastLimit (atOrPastLimit),
    .ctl           (ctl)
  );

  refresh_row_dp #(.CNT_W(CNT_W), .SEL_W(SEL_W)) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .limitSel      (limitSel),
    .count         (rowAddr),
    .atOrPastLimit (atOrPastLimit),
    .eocOutN       (eocOutN)
  );

endmodule

// File: tb/test_refresh_row_counter.sv
module test_refresh_row_counter;

  localparam int PERIOD = 10;
  localparam int NVEC   = 9;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       incStrobe = 1'b0;
  logic       loadStrobe = 1'b0;
  logic [1:0] limitSel = 2'b00;
  logic       eocInN = 1'b1;
  logic       eocOutN;
  logic [8:0] rowAddr;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  refresh_row_counter i_refresh_row_counter (
    .clk(clk), .rstN(rstN), .incStrobe(incStrobe), .loadStrobe(loadStrobe),
    .limitSel(limitSel), .eocInN(eocInN), .eocOutN(eocOutN), .rowAddr(rowAddr)
  );

  // Fields: req[4] inc load sel[2] clrN expCount[9] expInd
  localparam logic [18:0] VEC [NVEC] = '{
    {4'd2,  1'b1, 1'b0, 2'b00, 1'b1, 9'd1, 1'b1},  // R2 step
    {4'd2,  1'b0, 1'b0, 2'b00, 1'b1, 9'd1, 1'b1},  // R2 hold
    {4'd2,  1'b1, 1'b0, 2'b00, 1'b1, 9'd2, 1'b1},  // R2 step
    {4'd7,  1'b0, 1'b0, 2'b00, 1'b0, 9'd0, 1'b1},  // R7 clear
    {4'd8,  1'b1, 1'b0, 2'b00, 1'b0, 9'd0, 1'b1},  // R8 clear beats step
    {4'd10, 1'b0, 1'b1, 2'b01, 1'b1, 9'd0, 1'b1},  // R10 load only
    {4'd10, 1'b1, 1'b1, 2'b11, 1'b1, 9'd1, 1'b1},  // R10 load with step
    {4'd10, 1'b0, 1'b1, 2'b10, 1'b1, 9'd1, 1'b1},  // R10 load 511
    {4'd10, 1'b0, 1'b1, 2'b00, 1'b1, 9'd1, 1'b1}   // R10 load back to 127
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic inc, input logic ld, input logic [1:0] sel,
                       input logic clrN);
    incStrobe = inc; loadStrobe = ld; limitSel = sel; eocInN = clrN;
    @(negedge clk);
    incStrobe = 1'b0; loadStrobe = 1'b0; eocInN = 1'b1;
  endtask

  task automatic stepN(input int n);
    for (int i = 0; i < n; i++) apply(1'b1, 1'b0, 2'b00, 1'b1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", rowAddr, 0);
    check("R1", eocOutN, 1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", rowAddr, 0);

    for (int v = 0; v < NVEC; v++) begin
      apply(VEC[v][14], VEC[v][13], VEC[v][12:11], VEC[v][10]);
      check($sformatf("R%0d vec%0d count", VEC[v][18:15], v), rowAddr, VEC[v][9:1]);
      check($sformatf("R%0d vec%0d ind", VEC[v][18:15], v), eocOutN, VEC[v][0]);
    end

    // R4/R5: limit 127, count from 1 to 127
    stepN(125);
    check("R4 below", eocOutN, 1);
    stepN(1);
    check("R4 at 127", rowAddr, 127);
    check("R4 at 127", eocOutN, 0);
    stepN(1);
    check("R5 wrap", rowAddr, 0);
    check("R5 release", eocOutN, 1);

    // R6: count past a lowered limit
    apply(1'b0, 1'b1, 2'b01, 1'b1);
    stepN(200);
    apply(1'b0, 1'b1, 2'b00, 1'b1);
    check("R4 above limit", eocOutN, 1);
    check("R6 pre", rowAddr, 200);
    stepN(1);
    check("R6 wrap above", rowAddr, 0);

    // R3: code 01 gives 255
    apply(1'b0, 1'b1, 2'b01, 1'b1);
    stepN(255);
    check("R3 255", eocOutN, 0);
    stepN(1);
    check("R3 255 wrap", rowAddr, 0);

    // R9: code 10 gives 511 through full width
    apply(1'b0, 1'b1, 2'b10, 1'b1);
    stepN(255);
    check("R9 no ind at 255", eocOutN, 1);
    stepN(256);
    check("R9 at 511", rowAddr, 511);
    check("R9 ind", eocOutN, 0);
    stepN(1);
    check("R9 wrap", rowAddr, 0);

    // R3: code 11 also gives 511
    apply(1'b0, 1'b1, 2'b11, 1'b1);
    stepN(300);
    check("R3 code 11 beyond 255", rowAddr, 300);
    stepN(211);
    check("R3 code 11 at 511", eocOutN, 0);

    // R1: reset mid-run restores limit 127
    stepN(1);
    stepN(40);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset count", rowAddr, 0);
    rstN = 1'b1;
    @(negedge clk);
    stepN(127);
    check("R1 limit 127", eocOutN, 0);

    finish_run();
  end

endmodule